// File: doc/BRIEF.md
# Per-Processor Soft Interrupt Pending Bank

This block keeps a 32-bit interrupt pending word for each of up to sixteen processors. Software reaches the words over a simple word-addressed register bus. Each processor owns one 4 KiB page of the address space: address bits [15:12] pick the processor, and address bits [3:2] pick one of four register slots inside that page.

Slot 0 returns the processor's pending word. A write to slot 1 removes bits from that word, and a write to slot 2 raises soft-interrupt bits in it. Software may only touch the upper fifteen bits. The lower bits carry hardware interrupt levels.

A separate side port from the system interrupt router raises or drops one hardware level bit in one processor's word. Arbitration between processors and trap generation happen elsewhere. This block only holds the pending state and reports it.

Top module: `softint_bank`

## Requirements
- R1: There are sixteen independent pending words. A bus access reaches only the word chosen by `bus_addr[15:12]`; the other fifteen words keep their values.
- R2: A read at slot 0 (`bus_addr[3:2]` = 0) returns the selected word on `bus_rdata` one cycle later, with `bus_rvalid` high for exactly that one cycle. The value returned is the one held before any update made in the same cycle as the read.
- R3: A read at slot 1, 2 or 3 returns zero, with `bus_rvalid` behaving as in R2.
- R4: A write at slot 2 ORs `bus_wdata & 32'hFFFE0000` into the selected word.
- R5: A write at slot 1 clears the bits of `bus_wdata & 32'hFFFE0000` in the selected word. When `bus_wdata[14]` is 1, bit 31 is cleared as well.
- R6: No software write changes bits 16 down to 0 of any word.
- R7: Writes at slot 0 and slot 3 have no effect.
- R8: When `hw_valid` is 1, bit `hw_level` of word `hw_cpu` is set if `hw_set` is 1 and cleared if `hw_set` is 0. A request with `hw_level` = 0 has no effect.
- R9: A software write and a hardware request in the same cycle are both applied. The hardware update is applied after the software mask operation, including when both target the same word.
- R10: A synchronous active-high reset clears every word, `bus_rvalid` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 16 | Byte address: bits [15:12] select the processor, bits [3:2] select the slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| hw_valid | input | 1 | Hardware level update request |
| hw_cpu | input | 4 | Target processor for the hardware update |
| hw_level | input | 4 | Level bit to update (1 to 15; 0 is ignored) |
| hw_set | input | 1 | 1 sets the level bit, 0 clears it |

## Verification
Some rules are checked by assertions on every cycle. These are:
- software writes never disturb the low seventeen bits of a word;
- a set write leaves all of its masked bits high;
- a hardware set leaves its level bit high;
- reset clears each word;
- every read strobe yields a valid strobe one cycle later, with zero data for slots other than 0.

Some behaviour can only be shown by the bench's scenarios against its reference model. This covers the bit-14 to bit-31 coupling, the isolation of one processor's word from accesses to another, writes to slots 0 and 3 being ignored, level-0 requests being ignored, and the combined effect of a software write and a hardware request that land in the same cycle.

// File: rtl/softint_pkg.sv
package softint_pkg;
  typedef enum logic [1:0] {
    SLOT_PEND = 2'd0,
    SLOT_CLR  = 2'd1,
    SLOT_SET  = 2'd2,
    SLOT_RSVD = 2'd3
  } slot_e;

  // Bits reachable by software writes
  localparam logic [31:0] SW_MASK = 32'hFFFE_0000;

  // Build the clear vector: masked data, plus bit 31 when data bit 14 is set
  function automatic logic [31:0] clear_vector(input logic [31:0] wdata);
    logic [31:0] v;
    v = wdata & SW_MASK;
    if (wdata[14]) v[31] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/softint_decode.sv
module softint_decode #(
  parameter int NUM_CPUS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int CPU_LSB  = 12,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [NUM_CPUS-1:0] set_sel,
  output logic [NUM_CPUS-1:0] clr_sel,
  output logic [DATA_W-1:0]   set_bits,
  output logic [DATA_W-1:0]   clr_bits,
  output logic [CPU_W-1:0]    cpu_idx,
  output softint_pkg::slot_e  slot
);
  import softint_pkg::*;

  assign cpu_idx  = bus_addr[CPU_LSB +: CPU_W];
  assign slot     = slot_e'(bus_addr[3:2]);
  assign set_bits = bus_wdata & SW_MASK;
  assign clr_bits = clear_vector(bus_wdata);

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_sel
    logic hit;
    assign hit        = bus_wr && (cpu_idx == CPU_W'(i));
    assign set_sel[i] = hit && (slot == SLOT_SET);
    assign clr_sel[i] = hit && (slot == SLOT_CLR);
  end
endmodule

// File: rtl/softint_cell.sv
module softint_cell #(
  parameter int          DATA_W  = 32,
  parameter int          LVL_W   = 4,
  parameter logic [31:0] SW_MASK = 32'hFFFE_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] set_bits,
  input  logic [DATA_W-1:0] clr_bits,
  input  logic              hw_en,
  input  logic [LVL_W-1:0]  hw_bit,
  input  logic              hw_set,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] after_sw;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    after_sw = q;
    if (clr_en) after_sw = after_sw & ~clr_bits;
    if (set_en) after_sw = after_sw | set_bits;
    nxt = after_sw;
    if (hw_en) nxt[hw_bit] = hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

  // R6
  low_bits_sw_proof_chk: assert property (@(posedge clk) disable iff (rst)
    !hw_en |=> ((q & ~SW_MASK[DATA_W-1:0]) == ($past(q) & ~SW_MASK[DATA_W-1:0])));

  // R4
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && !hw_en) |=> ((q & $past(set_bits)) == $past(set_bits)));

  // R8
  hw_set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_en && hw_set) |=> q[$past(hw_bit)]);
endmodule

// File: rtl/softint_rdport.sv
module softint_rdport #(
  parameter int NUM_CPUS = 16,
  parameter int DATA_W   = 32,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd,
  input  logic [CPU_W-1:0]               cpu_idx,
  input  softint_pkg::slot_e             slot,
  input  logic [NUM_CPUS-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]              rdata,
  output logic                           rvalid
);
  import softint_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= (slot == SLOT_PEND) ? words[cpu_idx] : '0;
    end
  end

  // R2
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
  // R2
  rvalid_single_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);
  // R3
  rsvd_slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && slot != SLOT_PEND) |=> (rdata == '0));
endmodule

// File: rtl/softint_bank.sv
module softint_bank #(
  parameter int NUM_CPUS = 16,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int CPU_LSB  = 12,
  parameter int LVL_W    = 4,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              hw_valid,
  input  logic [CPU_W-1:0]  hw_cpu,
  input  logic [LVL_W-1:0]  hw_level,
  input  logic              hw_set
);
  import softint_pkg::*;

  logic [NUM_CPUS-1:0]             set_sel;
  logic [NUM_CPUS-1:0]             clr_sel;
  logic [DATA_W-1:0]               set_bits;
  logic [DATA_W-1:0]               clr_bits;
  logic [CPU_W-1:0]                cpu_idx;
  slot_e                           slot;
  logic [NUM_CPUS-1:0][DATA_W-1:0] words;
  logic                            hw_live;

  assign hw_live = hw_valid && (hw_level != '0);

  softint_decode #(
    .NUM_CPUS(NUM_CPUS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CPU_LSB(CPU_LSB)
  ) u_decode (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .set_sel  (set_sel),
    .clr_sel  (clr_sel),
    .set_bits (set_bits),
    .clr_bits (clr_bits),
    .cpu_idx  (cpu_idx),
    .slot     (slot)
  );

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cell
    softint_cell #(
      .DATA_W(DATA_W), .LVL_W(LVL_W), .SW_MASK(SW_MASK)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .set_en  (set_sel[i]),
      .clr_en  (clr_sel[i]),
      .set_bits(set_bits),
      .clr_bits(clr_bits),
      .hw_en   (hw_live && (hw_cpu == CPU_W'(i))),
      .hw_bit  (hw_level),
      .hw_set  (hw_set),
      .q       (words[i])
    );
  end

  softint_rdport #(
    .NUM_CPUS(NUM_CPUS), .DATA_W(DATA_W)
  ) u_rdport (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .cpu_idx(cpu_idx),
    .slot   (slot),
    .words  (words),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  // R1
  one_word_per_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_sel | clr_sel));
endmodule

// File: tb/softint_bank_tb.sv
`timescale 1ns/1ps
module softint_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        hw_valid = 1'b0;
  logic [3:0]  hw_cpu = '0, hw_level = '0;
  logic        hw_set = 1'b0;

  int    n_checks = 0, n_fail = 0;
  string tag = "R10";
  bit    done = 1'b0;

  logic [31:0] mdl [16];
  logic [31:0] exp_rdata = '0;
  logic        exp_rvalid = 1'b0;

  softint_bank u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .hw_valid(hw_valid), .hw_cpu(hw_cpu),
    .hw_level(hw_level), .hw_set(hw_set)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference model, updated on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mdl[i] = '0;
      exp_rvalid = 1'b0;
      exp_rdata  = '0;
    end else begin
      int c;
      logic [31:0] v;
      c = bus_addr[15:12];
      exp_rvalid = bus_rd;
      if (bus_rd) exp_rdata = (bus_addr[3:2] == 2'd0) ? mdl[c] : 32'd0;
      if (bus_wr && bus_addr[3:2] == 2'd1) begin
        v = bus_wdata & 32'hFFFE0000;
        if (bus_wdata[14]) v = v | 32'h80000000;
        mdl[c] = mdl[c] & ~v;
      end
      if (bus_wr && bus_addr[3:2] == 2'd2)
        mdl[c] = mdl[c] | (bus_wdata & 32'hFFFE0000);
      if (hw_valid && hw_level != 0) mdl[hw_cpu][hw_level] = hw_set;
    end
  end

  // Compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_checks++;
      if (bus_rvalid !== exp_rvalid) begin
        n_fail++;
        $display("FAIL %s rvalid actual=%0b expected=%0b", tag, bus_rvalid, exp_rvalid);
      end
      if (exp_rvalid) begin
        n_checks++;
        if (bus_rdata !== exp_rdata) begin
          n_fail++;
          $display("FAIL %s rdata actual=%08h expected=%08h", tag, bus_rdata, exp_rdata);
        end
      end
    end
  end

  function automatic logic [15:0] adr(input int cpu, input int slot);
    return {cpu[3:0], 8'h00, slot[1:0], 2'b00};
  endfunction

  task automatic idle();
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; hw_valid = 0;
  endtask

  task automatic wr(input int cpu, input int slot, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; hw_valid = 0; bus_addr = adr(cpu, slot); bus_wdata = d;
  endtask

  task automatic rd(input int cpu, input int slot);
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; hw_valid = 0; bus_addr = adr(cpu, slot);
  endtask

  task automatic hw(input int cpu, input int lvl, input bit s);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; hw_valid = 1;
    hw_cpu = cpu[3:0]; hw_level = lvl[3:0]; hw_set = s;
  endtask

  task automatic read_all();
    for (int i = 0; i < 16; i++) rd(i, 0);
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    tag = "R10"; read_all();
    tag = "R4";  wr(3, 2, 32'hFFFF_FFFF); rd(3, 0); idle();
    wr(5, 2, 32'h0002_0000); rd(5, 0); idle();
    tag = "R6";  wr(6, 2, 32'h0001_FFFF); rd(6, 0); idle();
    tag = "R1";  read_all();
    tag = "R5";  wr(3, 1, 32'h0F00_0000); rd(3, 0); idle();
    wr(3, 1, 32'h0000_4000); rd(3, 0); idle();
    wr(3, 1, 32'h0002_0000); rd(3, 0); idle();
    tag = "R7";  wr(5, 0, 32'hFFFF_FFFF); wr(5, 3, 32'hFFFF_FFFF); rd(5, 0); idle();
    tag = "R3";  rd(3, 1); rd(3, 2); rd(3, 3); idle();
    tag = "R8";  hw(9, 7, 1); hw(9, 15, 1); hw(9, 1, 1); rd(9, 0); idle();
    hw(9, 7, 0); rd(9, 0); idle();
    hw(9, 0, 1); hw(10, 0, 1); rd(9, 0); rd(10, 0); idle();
    tag = "R9";
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_addr = adr(9, 2); bus_wdata = 32'h8004_0000;
    hw_valid = 1; hw_cpu = 9; hw_level = 2; hw_set = 1;
    @(negedge clk);
    bus_wr = 1; bus_addr = adr(9, 1); bus_wdata = 32'h0000_4000;
    hw_valid = 1; hw_cpu = 9; hw_level = 15; hw_set = 0;
    rd(9, 0); idle();
    tag = "R2";
    @(negedge clk);
    bus_wr = 1; bus_rd = 1; hw_valid = 0; bus_addr = adr(12, 0); bus_wdata = 32'hFFFF_FFFF;
    wr(12, 2, 32'h1234_0000); rd(12, 0); rd(12, 0); idle(); idle();
    tag = "R1";  read_all();
    tag = "R10";
    @(negedge clk); rst = 1; bus_wr = 0; bus_rd = 0; hw_valid = 0;
    @(negedge clk);
    n_checks++;
    if (bus_rvalid !== 1'b0 || bus_rdata !== 32'd0) begin
      n_fail++;
      $display("FAIL R10 reset outputs actual=%0b/%08h expected=0/00000000", bus_rvalid, bus_rdata);
    end
    rst = 0;
    read_all();
    idle();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule